// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one burst access to a double-data-rate memory, one address per clock cycle. A controller gives it a start column, a three-bit burst length code and a one-bit ordering select, and pulses a start input. From the next cycle on the block presents the burst beats in order. It flags each beat as valid and marks the final beat. Address wrap stays inside the aligned window of 2, 4 or 8 columns that the burst length selects. The column bits above that window stay at their start values for the whole burst.

Two orderings are available. Sequential ordering counts upward from the start column and wraps at the window edge. Interleaved ordering takes the start column's window bits XOR the beat index. A stop input ends a burst early, for example when a precharge or burst-stop command is issued. A new start pulse during a burst drops the old burst and begins the new one at once. A start with a reserved length code produces no beats and raises an error flag instead.

Control is a three-state machine. IDLE has no burst in progress. BURST presents beats. FAULT holds the error flag. The transitions are named as follows. "launch": IDLE or FAULT to BURST, on start with a valid code. "reject": IDLE, FAULT or BURST to FAULT, on start with a reserved code. "relaunch": BURST to BURST, on start with a valid code. "cut": BURST to IDLE, on stop without start. "finish": BURST to IDLE, after the final beat. "hold": every other case keeps the current state.

Top module: `burst_col_seq`

## Requirements
- R1: Length codes 3'b001, 3'b010 and 3'b011 give bursts of 2, 4 and 8 beats. The beats appear in consecutive cycles with `beat_vld_o` high. The first beat is presented in the cycle after the clock edge that samples `start_i`, and it equals the start column.
- R2: With `ilv_i` = 0 (sequential), the low log2(N) bits of beat i are (start low bits + i) modulo N, where N is the burst length.
- R3: With `ilv_i` = 1 (interleaved), the low log2(N) bits of beat i are the start low bits XOR i.
- R4: Column bits at or above position log2(N) equal the start column's bits on every beat. This includes the window-sized bits that the selected length does not use.
- R5: `last_o` is high only together with the final beat of a burst that is not cut short. After the final beat, `beat_vld_o` goes low unless a new start was sampled.
- R6: A start with a reserved length code (3'b000 or 3'b100 to 3'b111) produces no beats. It also ends any burst in progress. `err_o` goes high from the next cycle and stays high until a start with a valid code is sampled, which clears it.
- R7: `stop_i` sampled high during a burst ends it, with no beat after that edge. `stop_i` outside a burst has no effect.
- R8: A start sampled during a burst drops the remaining beats and presents the new burst's first beat in the next cycle. Start takes priority over a stop sampled on the same edge.
- R9: After reset, and whenever `beat_vld_o` is low, `col_o` is zero and `last_o` is low. `err_o` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start pulse |
| col_i | input | COL_W | Start column address |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Cut the current burst short |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of the burst |
| err_o | output | 1 | Last start carried a reserved length code |

## Verification
The hardest cases to reach are those where control inputs collide with a burst in flight. Examples are a start arriving in the middle of an 8-beat burst while stop is also high, and a reserved-code start that must kill a running burst and leave the error flag set. The bench reaches these through directed sequences that drive inputs on the falling edge at a chosen beat count. It then checks the beat stream cycle by cycle afterwards. A table walk covers both orderings at every length, with start columns whose unused window bits are set, so that wrap leakage into those bits shows up.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FAULT = 2'd2
    } bcs_state_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
#(
    parameter int WIN_W = 3
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic                  ok_o,
    output logic [WIN_W-1:0]      mask_o
);
    always_comb begin
        ok_o = (code_i != '0) && (int'(code_i) <= WIN_W);
        for (int k = 0; k < WIN_W; k++) begin
            mask_o[k] = ok_o && (k < int'(code_i));
        end
    end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [WIN_W-1:0] idx_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clr_i) begin
            idx_o <= '0;
        end else if (adv_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (idx_o == '0));
endmodule

// File: rtl/bcs_order_gen.sv
module bcs_order_gen #(
    parameter int COL_W = 10,
    parameter int WIN_W = 3
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [WIN_W-1:0] mask_i,
    input  logic             ilv_i,
    input  logic [WIN_W-1:0] idx_i,
    output logic [COL_W-1:0] col_o
);
    logic [WIN_W-1:0] base_low;
    logic [WIN_W-1:0] step;
    logic [WIN_W-1:0] low_out;

    assign base_low = base_i[WIN_W-1:0];

    always_comb begin
        if (ilv_i) begin
            step = base_low ^ idx_i;
        end else begin
            step = base_low + idx_i;
        end
        low_out = (base_low & ~mask_i) | (step & mask_i);
    end

    assign col_o[WIN_W-1:0] = low_out;

    generate
        if (COL_W > WIN_W) begin : g_upper
            assign col_o[COL_W-1:WIN_W] = base_i[COL_W-1:WIN_W];
        end
    endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int WIN_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [LEN_CODE_W-1:0] blen_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  beat_vld_o,
    output logic                  last_o,
    output logic                  err_o
);
    bcs_state_e       state_q, state_d;
    logic             code_ok;
    logic [WIN_W-1:0] mask_in;
    logic [WIN_W-1:0] mask_q;
    logic [COL_W-1:0] base_q;
    logic             ilv_q;
    logic [WIN_W-1:0] idx;
    logic [COL_W-1:0] gen_col;
    logic             at_end;

    bcs_len_decode #(.WIN_W(WIN_W)) u_dec (
        .code_i (blen_i),
        .ok_o   (code_ok),
        .mask_o (mask_in)
    );

    bcs_beat_ctr #(.WIN_W(WIN_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .adv_i (state_q == ST_BURST),
        .idx_o (idx)
    );

    bcs_order_gen #(.COL_W(COL_W), .WIN_W(WIN_W)) u_ord (
        .base_i (base_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .idx_i  (idx),
        .col_o  (gen_col)
    );

    assign at_end = (idx == mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start_i && code_ok) begin
            base_q <= col_i;
            mask_q <= mask_in;
            ilv_q  <= ilv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (start_i) begin
                    state_d = code_ok ? ST_BURST : ST_FAULT;
                end
            end
            ST_BURST: begin
                if (start_i) begin
                    state_d = code_ok ? ST_BURST : ST_FAULT;
                end else if (stop_i || at_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        beat_vld_o = 1'b0;
        last_o     = 1'b0;
        err_o      = 1'b0;
        col_o      = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST: begin
                beat_vld_o = 1'b1;
                last_o     = at_end;
                col_o      = gen_col;
            end
            ST_FAULT: err_o = 1'b1;
            default: ;
        endcase
    end

    p_first_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && code_ok) |=> (beat_vld_o && col_o == $past(col_i)));

    p_last_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);

    p_reserved_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !code_ok) |=> (err_o && !beat_vld_o));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !beat_vld_o);

    p_stop_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && stop_i && !start_i) |=> !beat_vld_o);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> (col_o == '0 && !last_o));

    generate
        if (COL_W > WIN_W) begin : g_upper_chk
            p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (beat_vld_o && !last_o && !start_i && !stop_i)
                |=> $stable(col_o[COL_W-1:WIN_W]));
        end
    endgenerate
endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
    localparam int COL_W = 10;
    localparam int NV    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       blen_i = 3'b000;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o, last_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .WIN_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o), .err_o(err_o)
    );

    // {expected low-3 bits beat7..beat0, ilv, blen, start col}
    localparam logic [37:0] VEC [NV] = '{
        {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd5, 1'b0, 3'b001, 10'h2A5},
        {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd5, 1'b1, 3'b001, 10'h2A5},
        {3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd2,3'd1, 1'b0, 3'b010, 10'h041},
        {3'd0,3'd0,3'd0,3'd0,3'd6,3'd7,3'd4,3'd5, 1'b1, 3'b010, 10'h04D},
        {3'd2,3'd3,3'd0,3'd1,3'd6,3'd7,3'd4,3'd5, 1'b1, 3'b011, 10'h3FD},
        {3'd4,3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5, 1'b0, 3'b011, 10'h3FD},
        {3'd0,3'd0,3'd0,3'd0,3'd5,3'd4,3'd7,3'd6, 1'b0, 3'b010, 10'h10E},
        {3'd4,3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3, 1'b1, 3'b011, 10'h10B}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [COL_W-1:0] c, input logic [2:0] bl,
                          input logic il, input logic stp);
        @(negedge clk);
        start_i = 1'b1; col_i = c; blen_i = bl; ilv_i = il; stop_i = stp;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!beat_vld_o && !last_o && !err_o && col_o == '0, "R9 reset",
            {col_o, beat_vld_o, last_o, err_o}, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: table walk
        for (int v = 0; v < NV; v++) begin
            logic [COL_W-1:0] sc;
            int nb;
            sc = VEC[v][9:0];
            nb = 1 << VEC[v][12:10];
            launch(sc, VEC[v][12:10], VEC[v][13], 1'b0);
            for (int b = 0; b < nb; b++) begin
                logic [COL_W-1:0] ec;
                ec = {sc[COL_W-1:3], VEC[v][14 + 3*b +: 3]};
                chk(beat_vld_o, "R1 beat valid", beat_vld_o, 1);
                chk(col_o == ec, VEC[v][13] ? "R3 R4 interleaved column" : "R2 R4 sequential column",
                    col_o, ec);
                chk(last_o == (b == nb - 1), "R5 last flag", last_o, b == nb - 1);
                @(negedge clk);
            end
            chk(!beat_vld_o && col_o == '0, "R5 R9 burst over", {beat_vld_o, col_o}, 0);
        end

        // R6: reserved codes
        launch(10'h155, 3'b000, 1'b0, 1'b0);
        chk(err_o && !beat_vld_o, "R6 code 000", {err_o, beat_vld_o}, 2);
        @(negedge clk);
        chk(err_o && !beat_vld_o, "R6 err held", {err_o, beat_vld_o}, 2);
        launch(10'h155, 3'b111, 1'b1, 1'b0);
        chk(err_o && !beat_vld_o, "R6 code 111", {err_o, beat_vld_o}, 2);
        launch(10'h155, 3'b010, 1'b0, 1'b0);
        chk(!err_o && beat_vld_o && col_o == 10'h155, "R6 valid start clears", {err_o, col_o}, 10'h155);
        // reserved start kills a running burst
        @(negedge clk);
        start_i = 1'b1; blen_i = 3'b100;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o && !beat_vld_o, "R6 kills burst", {err_o, beat_vld_o}, 2);
        repeat (3) @(negedge clk);
        chk(!beat_vld_o, "R6 no beats", beat_vld_o, 0);

        // R7: stop mid burst
        launch(10'h020, 3'b011, 1'b0, 1'b0);
        @(negedge clk); @(negedge clk);
        chk(beat_vld_o && col_o == 10'h022, "R7 before stop", col_o, 10'h022);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(!beat_vld_o && !last_o, "R7 stop cuts", beat_vld_o, 0);
        repeat (2) @(negedge clk);
        chk(!beat_vld_o, "R7 stays stopped", beat_vld_o, 0);
        // R7: stop while idle is ignored
        stop_i = 1'b1;
        repeat (2) @(negedge clk);
        stop_i = 1'b0;
        chk(!beat_vld_o && !err_o && col_o == '0, "R7 idle stop", {beat_vld_o, err_o}, 0);
        launch(10'h0F3, 3'b001, 1'b0, 1'b0);
        chk(beat_vld_o && col_o == 10'h0F3, "R7 start after idle stop", col_o, 10'h0F3);
        @(negedge clk);
        chk(col_o == 10'h0F2 && last_o, "R7 R2 beat 1", col_o, 10'h0F2);

        // R8: restart mid burst, with stop on the same edge
        launch(10'h200, 3'b011, 1'b0, 1'b0);
        @(negedge clk);
        chk(col_o == 10'h201, "R8 old burst beat 1", col_o, 10'h201);
        start_i = 1'b1; col_i = 10'h086; blen_i = 3'b010; ilv_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk(beat_vld_o && col_o == 10'h086 && !last_o, "R8 new beat 0", col_o, 10'h086);
        @(negedge clk);
        chk(col_o == 10'h087, "R8 R3 new beat 1", col_o, 10'h087);
        @(negedge clk);
        chk(col_o == 10'h084, "R8 R3 new beat 2", col_o, 10'h084);
        @(negedge clk);
        chk(col_o == 10'h085 && last_o, "R8 R5 new beat 3", col_o, 10'h085);
        @(negedge clk);
        chk(!beat_vld_o, "R8 old beats dropped", beat_vld_o, 0);

        // R8: back-to-back start on the last beat
        launch(10'h001, 3'b001, 1'b0, 1'b0);
        @(negedge clk);
        chk(last_o && col_o == 10'h000, "R5 last before chain", col_o, 10'h000);
        start_i = 1'b1; col_i = 10'h3F8; blen_i = 3'b001; ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(beat_vld_o && col_o == 10'h3F8, "R8 chained start", col_o, 10'h3F8);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule